// File: doc/BRIEF.md
# Crossbar Epoch Allocator

This block decides, once per fixed-length epoch, which source card may send to which destination card across a 15-port switched backplane. Every source presents a row of request bits, one per destination it holds cells for. Every destination presents an inhibit bit that refuses new traffic. The allocator takes a snapshot of both at the start of an epoch. It then builds a conflict-free pairing during the rest of that epoch and publishes it at the start of the next epoch. The published pairing stays fixed for a whole epoch, so the cards have that time to configure for the transfer.

The pairing is built by a greedy sweep. Sources that belong to forwarding engines are visited first and line cards second. Within each class, sources are visited from a rotating start point. Each source takes the first free, requested and uninhibited destination, searched from a second rotating start point. A 16-bit LFSR picks both start points fresh each epoch, so no port number is favoured over time. Several sweep steps are evaluated combinationally in each clock, so the 30 steps of a sweep fit into one epoch.

Top module: `xbar_alloc`

## Requirements
- R1: While reset is high and in the first cycle after it, the grant matrix and the busy vector are all zero and `epoch_start` is high.
- R2: `epoch_start` is high in exactly one cycle out of every 8 (EPOCH_CYC), beginning with the first cycle after reset is released.
- R3: Requests and inhibits are sampled at the clock edge that ends an `epoch_start` cycle. The pairing built from them appears on `grant` at the edge that ends the next `epoch_start` cycle, and it stays unchanged for 8 cycles. Bit s*15+d of `req` and of `grant` refers to source s and destination d.
- R4: Each source has at most one grant bit set, and each destination is granted to at most one source.
- R5: A grant for source s and destination d is given only if request bit s*15+d was set and `inhibit[d]` was low when they were sampled.
- R6: The pairing is maximal. No sampled request with a low inhibit is left where both its source and its destination are without a grant.
- R7: Every source marked in FE_MASK (default ports 0 to 2) is visited before any unmarked source. A marked source therefore wins any destination that it competes for against an unmarked one.
- R8: Within each class, sources are visited in the order (so+p) mod 15 for p = 0..14. Each visited source takes the first eligible free destination in the order (do+q) mod 15.
- R9: The 16-bit LFSR value L is 16'hACE1 after reset. It advances at each sampling edge to {L[14:0], L[15]^L[13]^L[12]^L[10]}. The offsets are so = L[7:0] mod 15 and do = L[15:8] mod 15, both taken from L before that edge advances it.
- R10: `dst_busy[d]` is high exactly when some source holds a grant for destination d in the current grant matrix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Allocation clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 225 | Request matrix, bit s*15+d: source s has cells for destination d |
| inhibit | input | 15 | Per-destination refusal of new transfers |
| grant | output | 225 | Published pairing, bit s*15+d: source s sends to destination d |
| dst_busy | output | 15 | Destination d is paired in the published grant |
| epoch_start | output | 1 | High in the sampling cycle of each epoch |

## Verification
Two things happen on the same clock edge here. The snapshot for the new epoch is taken, and the pairing built from the previous snapshot is published. The bench provokes clashes at that edge by holding one pattern for a full epoch and switching to an unrelated one straight after. It also runs a phase in which requests and inhibits change on every cycle, so only the value at the sampling edge may influence the next grant. A behavioural model replays the sweep order, priority classes and LFSR. Its result is compared with the grant and strobe on every cycle. Each published pairing is also checked on its own for row and column uniqueness, inhibit respect and maximality against the inputs recorded one epoch earlier.

// File: rtl/xbar_alloc_pkg.sv
package xbar_alloc_pkg;

    localparam int NPORTS = 15;
    localparam int IDXW   = $clog2(NPORTS);
    localparam int LFSRW  = 16;

    typedef logic [NPORTS-1:0] pvec_t;
    typedef pvec_t [NPORTS-1:0] pmat_t;
    typedef logic [IDXW-1:0]   pidx_t;
    typedef logic [LFSRW-1:0]  lfsr_t;

    typedef struct packed {
        logic  hit;
        pidx_t src;
        pidx_t dst;
    } pick_t;

    // Sum of two port indices, both below NPORTS, folded back into range.
    function automatic pidx_t wrap_add(pidx_t a, pidx_t b);
        logic [IDXW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= (IDXW+1)'(NPORTS))
            s = s - (IDXW+1)'(NPORTS);
        return s[IDXW-1:0];
    endfunction

    // First set bit of cand, searching upward from position off with wrap.
    function automatic pick_t first_from(pvec_t cand, pidx_t off);
        pick_t r;
        pidx_t j;
        r = '0;
        for (int i = NPORTS - 1; i >= 0; i--) begin
            j = wrap_add(off, pidx_t'(i));
            if (cand[j]) begin
                r.hit = 1'b1;
                r.dst = j;
            end
        end
        return r;
    endfunction

    function automatic lfsr_t lfsr_next(lfsr_t v);
        return {v[LFSRW-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

endpackage

// File: rtl/xbar_epoch_seq.sv
module xbar_epoch_seq
    import xbar_alloc_pkg::*;
#(
    parameter int    EPOCH_CYC = 8,
    parameter int    LANES     = 5,
    parameter int    SW        = 6,
    parameter lfsr_t SEED      = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst,
    output logic          capture,
    output logic          scan_en,
    output logic [SW-1:0] step_base,
    output pidx_t         soff_q,
    output pidx_t         doff_q
);

    localparam int CW = $clog2(EPOCH_CYC);
    localparam logic [CW-1:0] LAST = CW'(EPOCH_CYC - 1);

    logic [CW-1:0] cnt_q;
    lfsr_t         lfsr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lfsr_q <= SEED;
            soff_q <= '0;
            doff_q <= '0;
        end else begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            if (cnt_q == '0) begin
                lfsr_q <= lfsr_next(lfsr_q);
                soff_q <= pidx_t'(lfsr_q[7:0]  % 8'(NPORTS));
                doff_q <= pidx_t'(lfsr_q[15:8] % 8'(NPORTS));
            end
        end
    end

    assign capture   = (cnt_q == '0);
    assign scan_en   = !capture;
    assign step_base = scan_en ? SW'((int'(cnt_q) - 1) * LANES) : '0;

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);                                             // R9
    AST_EPOCH_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> (cnt_q == '0));                        // R2
    AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (rst)
        (soff_q < pidx_t'(NPORTS)) && (doff_q < pidx_t'(NPORTS))); // R9

endmodule

// File: rtl/xbar_match_lane.sv
module xbar_match_lane
    import xbar_alloc_pkg::*;
#(
    parameter int LANE = 0,
    parameter int SW   = 6
) (
    input  logic          scan_en,
    input  logic [SW-1:0] step_base,
    input  pidx_t         soff,
    input  pidx_t         doff,
    input  pvec_t         fe_mask,
    input  pmat_t         req_m,
    input  pvec_t         inh,
    input  pvec_t         free_in,
    output pvec_t         free_out,
    output pick_t         pick
);

    logic [SW-1:0] k;
    logic [SW-1:0] pos;
    logic          in_range;
    logic          lc_pass;
    logic          class_ok;
    pidx_t         src;
    pvec_t         cand;
    pick_t         found;

    always_comb begin
        k        = step_base + SW'(LANE);
        in_range = scan_en && (k < SW'(2 * NPORTS));
        lc_pass  = (k >= SW'(NPORTS));
        pos      = lc_pass ? (k - SW'(NPORTS)) : k;
        src      = wrap_add(soff, pidx_t'(pos));
        class_ok = (fe_mask[src] != lc_pass);
        cand     = req_m[src] & ~inh & free_in;
        found    = first_from(cand, doff);

        pick.hit = in_range && class_ok && found.hit;
        pick.src = src;
        pick.dst = found.dst;

        free_out = free_in;
        if (pick.hit)
            free_out[found.dst] = 1'b0;
    end

endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
    import xbar_alloc_pkg::*;
#(
    parameter int    EPOCH_CYC = 8,
    parameter pvec_t FE_MASK   = 15'h0007,
    parameter lfsr_t LFSR_SEED = 16'hACE1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORTS*NPORTS-1:0] req,
    input  logic [NPORTS-1:0]        inhibit,
    output logic [NPORTS*NPORTS-1:0] grant,
    output logic [NPORTS-1:0]        dst_busy,
    output logic                     epoch_start
);

    localparam int SCAN_CYC = EPOCH_CYC - 1;
    localparam int STEPS    = 2 * NPORTS;
    localparam int LANES    = (STEPS + SCAN_CYC - 1) / SCAN_CYC;
    localparam int SW       = $clog2(STEPS + LANES) + 1;

    logic          capture;
    logic          scan_en;
    logic [SW-1:0] step_base;
    pidx_t         soff;
    pidx_t         doff;

    pmat_t req_m;
    pmat_t snap_req;
    pvec_t snap_inh;
    pmat_t work_q;
    pmat_t work_nx;
    pvec_t dfree_q;
    pmat_t grant_q;
    pmat_t grant_col;

    pvec_t free_c [LANES+1];
    pick_t pick_c [LANES];

    xbar_epoch_seq #(
        .EPOCH_CYC (EPOCH_CYC),
        .LANES     (LANES),
        .SW        (SW),
        .SEED      (LFSR_SEED)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .scan_en   (scan_en),
        .step_base (step_base),
        .soff_q    (soff),
        .doff_q    (doff)
    );

    assign free_c[0] = dfree_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        xbar_match_lane #(
            .LANE (l),
            .SW   (SW)
        ) u_lane (
            .scan_en   (scan_en),
            .step_base (step_base),
            .soff      (soff),
            .doff      (doff),
            .fe_mask   (FE_MASK),
            .req_m     (snap_req),
            .inh       (snap_inh),
            .free_in   (free_c[l]),
            .free_out  (free_c[l+1]),
            .pick      (pick_c[l])
        );
    end

    always_comb begin
        work_nx = work_q;
        for (int l = 0; l < LANES; l++)
            if (pick_c[l].hit)
                work_nx[pick_c[l].src][pick_c[l].dst] = 1'b1;
    end

    always_comb begin
        for (int s = 0; s < NPORTS; s++)
            for (int d = 0; d < NPORTS; d++) begin
                req_m[s][d]            = req[s*NPORTS + d];
                grant[s*NPORTS + d]    = grant_q[s][d];
                grant_col[d][s]        = grant_q[s][d];
            end
        for (int d = 0; d < NPORTS; d++)
            dst_busy[d] = |grant_col[d];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_req <= '0;
            snap_inh <= '0;
            work_q   <= '0;
            dfree_q  <= '1;
            grant_q  <= '0;
        end else if (capture) begin
            grant_q  <= work_q;
            work_q   <= '0;
            dfree_q  <= '1;
            snap_req <= req_m;
            snap_inh <= inhibit;
        end else begin
            work_q  <= work_nx;
            dfree_q <= free_c[LANES];
        end
    end

    assign epoch_start = capture;

    // Open-pair search over the finished pairing, for the maximality check.
    logic open_pair;
    always_comb begin
        open_pair = 1'b0;
        for (int s = 0; s < NPORTS; s++)
            for (int d = 0; d < NPORTS; d++)
                if (snap_req[s][d] && !snap_inh[d] && !(|work_q[s]) && dfree_q[d])
                    open_pair = 1'b1;
    end

    AST_MAXIMAL_MATCH: assert property (@(posedge clk) disable iff (rst)
        capture |-> !open_pair);                                   // R6
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(grant_q));                            // R3

    for (genvar g = 0; g < NPORTS; g++) begin : g_chk
        AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            $onehot0(grant_q[g]));                                 // R4
        AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            $onehot0(grant_col[g]));                               // R4
        AST_ELIGIBLE_ONLY: assert property (@(posedge clk) disable iff (rst)
            (work_q[g] & ~(snap_req[g] & ~snap_inh)) == '0);       // R5
    end

endmodule

// File: tb/xbar_alloc_test.sv
module xbar_alloc_test;

    localparam int N = 15;
    localparam int E = 8;
    localparam logic [N-1:0] FE = 15'h0007;
    localparam int WD_LIMIT = 20000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N*N-1:0] req = '0;
    logic [N-1:0]   inh = '0;
    logic [N*N-1:0] grant;
    logic [N-1:0]   dst_busy;
    logic           epoch_start;

    int n_cmp = 0;
    int n_bad = 0;
    bit run_chk = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xbar_alloc uut (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .inhibit     (inh),
        .grant       (grant),
        .dst_busy    (dst_busy),
        .epoch_start (epoch_start)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [N*N-1:0] ref_match(input logic [N*N-1:0] r,
                                                 input logic [N-1:0] ih,
                                                 input int so, input int dof);
        logic [N*N-1:0] g;
        logic [N-1:0]   taken;
        g = '0;
        taken = '0;
        for (int c = 0; c < 2; c++)
            for (int p = 0; p < N; p++) begin
                int s;
                bit got;
                s = (so + p) % N;
                got = 1'b0;
                if ((c == 0) == FE[s])
                    for (int q = 0; q < N; q++) begin
                        int d;
                        d = (dof + q) % N;
                        if (!got && r[s*N+d] && !ih[d] && !taken[d]) begin
                            g[s*N+d] = 1'b1;
                            taken[d] = 1'b1;
                            got = 1'b1;
                        end
                    end
            end
        return g;
    endfunction

    logic [N*N-1:0] m_pend, m_exp, m_req_cur, m_req_exp;
    logic [N-1:0]   m_inh_cur, m_inh_exp;
    logic [15:0]    m_lfsr;
    int             m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            m_lfsr = 16'hACE1;
            m_pend = '0; m_exp = '0;
            m_req_cur = '0; m_req_exp = '0;
            m_inh_cur = '0; m_inh_exp = '0;
        end else begin
            if (m_cnt == 0) begin
                m_exp     = m_pend;
                m_req_exp = m_req_cur;
                m_inh_exp = m_inh_cur;
                m_req_cur = req;
                m_inh_cur = inh;
                m_pend    = ref_match(req, inh, int'(m_lfsr[7:0]) % N,
                                      int'(m_lfsr[15:8]) % N);
                m_lfsr    = {m_lfsr[14:0], m_lfsr[15]^m_lfsr[13]^m_lfsr[12]^m_lfsr[10]};
            end
            m_cnt = (m_cnt + 1) % E;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [N*N-1:0] act, input logic [N*N-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [N-1:0] col_or(input logic [N*N-1:0] g);
        logic [N-1:0] v;
        v = '0;
        for (int s = 0; s < N; s++)
            for (int d = 0; d < N; d++)
                if (g[s*N+d]) v[d] = 1'b1;
        return v;
    endfunction

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (run_chk) begin
            // R3 R7 R8 R9: full pairing equals the reference sweep
            check(grant === m_exp, "R3 R7 R8 R9 grant", grant, m_exp);
            // R2: strobe framing
            check(epoch_start === (m_cnt == 0), "R2 epoch_start",
                  (N*N)'(epoch_start), (N*N)'(m_cnt == 0));
            // R10: busy vector is column OR of the grant
            check(dst_busy === col_or(m_exp), "R10 dst_busy",
                  (N*N)'(dst_busy), (N*N)'(col_or(m_exp)));
            if (m_cnt == 1) begin : new_grant
                bit rows_ok, cols_ok, elig_ok, max_ok;
                logic [N-1:0] dused, sused;
                rows_ok = 1'b1; cols_ok = 1'b1; elig_ok = 1'b1; max_ok = 1'b1;
                dused = '0; sused = '0;
                for (int s = 0; s < N; s++)
                    for (int d = 0; d < N; d++)
                        if (grant[s*N+d]) begin
                            if (sused[s]) rows_ok = 1'b0;
                            if (dused[d]) cols_ok = 1'b0;
                            sused[s] = 1'b1;
                            dused[d] = 1'b1;
                            if (!m_req_exp[s*N+d] || m_inh_exp[d]) elig_ok = 1'b0;
                        end
                for (int s = 0; s < N; s++)
                    for (int d = 0; d < N; d++)
                        if (m_req_exp[s*N+d] && !m_inh_exp[d] && !sused[s] && !dused[d])
                            max_ok = 1'b0;
                check(rows_ok && cols_ok, "R4 one grant per row and column", grant, m_exp);
                check(elig_ok, "R5 only requested uninhibited pairs", grant, m_req_exp);
                check(max_ok, "R6 maximal pairing", grant, m_req_exp);
            end
        end
    end

    task automatic hold_epoch(input logic [N*N-1:0] r, input logic [N-1:0] ih);
        req = r;
        inh = ih;
        repeat (E) @(negedge clk);
    endtask

    function automatic logic [N*N-1:0] to_dest(input int d, input logic [N-1:0] srcs);
        logic [N*N-1:0] r;
        r = '0;
        for (int s = 0; s < N; s++)
            if (srcs[s]) r[s*N+d] = 1'b1;
        return r;
    endfunction

    function automatic logic [N*N-1:0] rand_req(input bit sparse);
        logic [N*N-1:0] r;
        for (int s = 0; s < N; s++)
            r[s*N +: N] = sparse ? N'($urandom & $urandom) : N'($urandom);
        return r;
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [N*N-1:0] diag;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(grant === '0, "R1 grant in reset", grant, '0);
        check(dst_busy === '0, "R1 busy in reset", (N*N)'(dst_busy), '0);
        check(epoch_start === 1'b1, "R1 epoch_start in reset", (N*N)'(epoch_start), 1);
        rst = 1'b0;
        run_chk = 1'b1;

        hold_epoch('0, '0);
        // one destination wanted by all: a forwarding-engine source must win (R7)
        hold_epoch(to_dest(5, '1), '0);
        // only line cards plus one forwarding-engine source contend (R7)
        hold_epoch(to_dest(9, 15'h7FF8 | 15'h0002), '0);
        // all pairs requested: full pairing (R6)
        hold_epoch('1, '0);
        // half of the destinations inhibited (R5)
        hold_epoch('1, 15'h5555);
        // everything inhibited: no grant (R5)
        hold_epoch('1, '1);
        // diagonal
        diag = '0;
        for (int s = 0; s < N; s++) diag[s*N+s] = 1'b1;
        hold_epoch(diag, 15'h0100);
        // one source asks for all destinations (R8)
        hold_epoch({{(N*N-N){1'b0}}, {N{1'b1}}} << (7*N), '0);
        // random epochs, dense and sparse, with random inhibits
        for (int i = 0; i < 20; i++)
            hold_epoch(rand_req(i[0]), N'($urandom & $urandom));
        // inputs churn every cycle: only the sampled value counts (R3)
        for (int i = 0; i < 10 * E; i++) begin
            req = rand_req(i[1]);
            inh = N'($urandom & $urandom);
            @(negedge clk);
        end
        hold_epoch('0, '0);
        hold_epoch('0, '0);
        hold_epoch('0, '0);
        run_chk = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule